// File: doc/BRIEF.md
# FIFO-Buffered Asynchronous Serial Transmitter

This block is the sending side of an asynchronous serial port. The host pushes bytes into a 16-entry queue. The block then shifts each byte onto a single line as a character: a low start bit, then 7 or 8 data bits with the least significant bit first, then an optional parity bit, then one or two high stop bits. Bit timing comes from a baud enable supplied from outside the block at 16 pulses per bit period. Where that enable comes from (an internal divider or an external clock enable) does not matter to this block.

The character format is chosen at run time. The format in force when a character's start bit begins applies to the whole of that character. The host can read how many bytes are queued. The block raises a queue-empty request that can drive an interrupt or a DMA channel. A clear-to-send input from the modem holds back new characters, but it never cuts short a character that is already on the line. If the host writes while the queue is full, the write is dropped and a sticky flag is set. A done status shows when the queue is empty and the final stop bit has fully left the line.

Top module: `async_tx_fifo`

## Requirements
- R1: After reset the line `txd` is high, `fill_level` is 0, `overflow` is 0, and `tx_done` is 1. While no character is being sent, the line stays high.
- R2: A character starts with a low start bit. Every bit, the start bit included, lasts exactly 16 `baud_tick` pulses. `txd` changes only in the cycle after a `baud_tick` pulse. Data bits go out least significant bit first.
- R3: When `fmt_len7` is 1, only bits 6..0 of the queued byte are sent and bit 7 has no effect. When `fmt_len7` is 0, all 8 bits are sent.
- R4: `fmt_parity` selects the parity: 2'b01 is even, 2'b10 is odd, and 2'b00 or 2'b11 is none. With even or odd parity, one parity bit follows the data. It makes the number of ones in the sent data bits plus the parity bit even (even mode) or odd (odd mode). With no parity, no parity bit is sent.
- R5: After the data bits (and the parity bit, if any), the line is high for one stop bit when `fmt_stop2` is 0 and for two stop bits when it is 1.
- R6: `fill_level` shows the number of queued bytes that have not yet started, up to 16. When further bytes are queued and CTS is asserted, the next start bit begins in the same tick that ends the previous stop bit, with no idle time.
- R7: A write while 16 bytes are queued is discarded. It does not disturb the queued bytes and it sets `overflow`, which stays 1 until reset.
- R8: `empty_irq` and `empty_dma_req` are 1 exactly when `fill_level` was 0 in the previous cycle. They go high as soon as the last byte is taken for sending.
- R9: While `cts` is 0, no new start bit begins. `cts` is examined only when a character would start, so a character already under way always completes.
- R10: `tx_done` is 1 only when the queue is empty and the last stop bit has ended. It is 0 while any character is on the line.
- R11: The format inputs are captured when a start bit begins. A change in the middle of a character affects only the characters that start after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle enable, 16 per bit period |
| wr_en | input | 1 | Push `wr_data` into the queue |
| wr_data | input | 8 | Byte to send |
| fmt_len7 | input | 1 | 1: 7 data bits, 0: 8 data bits |
| fmt_stop2 | input | 1 | 1: two stop bits, 0: one |
| fmt_parity | input | 2 | 00/11 none, 01 even, 10 odd |
| cts | input | 1 | Clear to send, active high |
| txd | output | 1 | Serial line, idles high |
| fill_level | output | 5 | Number of queued bytes |
| empty_irq | output | 1 | Queue-empty interrupt request |
| empty_dma_req | output | 1 | Queue-empty DMA request |
| overflow | output | 1 | Sticky: a write to a full queue was dropped |
| tx_done | output | 1 | Queue empty and line idle after the last stop bit |

## Verification
The bench decodes the line at the middle of each bit for all twelve combinations of length, stop bits and parity. It also runs the spare no-parity code. The bytes always have bit 7 set, so a 7-bit design that leaks bit 7 into the parity shows a wrong parity bit. The bench measures the spacing between start bits to catch a one-tick gap between queued characters that a design would leave if it only started characters from idle. It overfills the queue and then drains all sixteen bytes: a design that wrapped the write pointer would send the dropped byte in place of the first. Finally, it pulls CTS low and changes the format in the middle of a character. A design that sampled CTS or the format continuously would either truncate that character or alter its tail.

// File: rtl/atx_pkg.sv
package atx_pkg;
  typedef enum logic [1:0] {
    PAR_OFF  = 2'b00,
    PAR_EVEN = 2'b01,
    PAR_ODD  = 2'b10,
    PAR_OFF2 = 2'b11
  } par_mode_e;

  function automatic logic par_enabled(input logic [1:0] m);
    return (m == PAR_EVEN) || (m == PAR_ODD);
  endfunction
endpackage

// File: rtl/atx_fifo.sv
module atx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           push_req,
  input  logic [DATA_W-1:0]              push_data,
  input  logic                           pop,
  output logic [DATA_W-1:0]              head,
  output logic [$clog2(DEPTH+1)-1:0]     level,
  output logic                           empty,
  output logic                           overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic              full, do_push;

  assign full    = (level == CW'(DEPTH));
  assign empty   = (level == '0);
  assign do_push = push_req && !full;
  assign head    = mem[rd_ptr];

  function automatic logic [AW-1:0] next_ptr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  // storage without reset so the array maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      level    <= '0;
      overflow <= 1'b0;
    end else begin
      if (do_push) wr_ptr <= next_ptr(wr_ptr);
      if (pop)     rd_ptr <= next_ptr(rd_ptr);
      if (do_push && !pop)      level <= level + CW'(1);
      else if (pop && !do_push) level <= level - CW'(1);
      if (push_req && full)     overflow <= 1'b1;
    end
  end

  assert_level_bound_R6: assert property (@(posedge clk) disable iff (rst)
    level <= CW'(DEPTH));
  assert_no_pop_when_empty_R6: assert property (@(posedge clk) disable iff (rst)
    pop |-> (level != '0));
  assert_full_write_dropped_R7: assert property (@(posedge clk) disable iff (rst)
    (push_req && level == CW'(DEPTH) && !pop) |=> (level == CW'(DEPTH) && overflow));
  assert_overflow_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
endmodule

// File: rtl/atx_serializer.sv
module atx_serializer #(
  parameter int DATA_W = 8,
  parameter int TICKS  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              avail,
  input  logic [DATA_W-1:0] head,
  input  logic              cfg_len7,
  input  logic              cfg_stop2,
  input  logic [1:0]        cfg_par,
  input  logic              cts,
  output logic              pop,
  output logic              txd,
  output logic              busy
);
  import atx_pkg::*;

  localparam int FRAME_W = DATA_W + 4;
  localparam int IW      = $clog2(FRAME_W + 1);
  localparam int TW      = (TICKS > 1) ? $clog2(TICKS) : 1;

  logic [FRAME_W-1:0] frame, shift_q;
  logic [IW-1:0]      dlen, nbits, nbits_q, bit_idx;
  logic [TW-1:0]      tick_cnt;
  logic [DATA_W-1:0]  dmask;
  logic               par_on, par_bit, bit_end, frame_end, load;

  // build the whole character from the queue head and current format
  assign dlen    = cfg_len7 ? IW'(DATA_W - 1) : IW'(DATA_W);
  assign dmask   = cfg_len7 ? {1'b0, {(DATA_W-1){1'b1}}} : '1;
  assign par_on  = par_enabled(cfg_par);
  assign par_bit = (^(head & dmask)) ^ (cfg_par == PAR_ODD);
  assign nbits   = IW'(1) + dlen + IW'(par_on) + (cfg_stop2 ? IW'(2) : IW'(1));

  always_comb begin
    frame    = '1;
    frame[0] = 1'b0;
    for (int i = 0; i < DATA_W; i++) begin
      if (IW'(i) < dlen) frame[i+1] = head[i];
    end
    if (par_on) frame[dlen + IW'(1)] = par_bit;
  end

  assign bit_end   = busy && tick && (tick_cnt == TW'(TICKS - 1));
  assign frame_end = bit_end && (bit_idx == nbits_q - IW'(1));
  assign load      = tick && avail && cts && (!busy || frame_end);
  assign pop       = load;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy     <= 1'b0;
      txd      <= 1'b1;
      shift_q  <= '1;
      nbits_q  <= '0;
      bit_idx  <= '0;
      tick_cnt <= '0;
    end else if (load) begin
      busy     <= 1'b1;
      txd      <= frame[0];
      shift_q  <= {1'b1, frame[FRAME_W-1:1]};
      nbits_q  <= nbits;
      bit_idx  <= '0;
      tick_cnt <= '0;
    end else if (frame_end) begin
      busy     <= 1'b0;
      txd      <= 1'b1;
      tick_cnt <= '0;
    end else if (bit_end) begin
      tick_cnt <= '0;
      bit_idx  <= bit_idx + IW'(1);
      txd      <= shift_q[0];
      shift_q  <= {1'b1, shift_q[FRAME_W-1:1]};
    end else if (busy && tick) begin
      tick_cnt <= tick_cnt + TW'(1);
    end
  end

  assert_idle_line_high_R1: assert property (@(posedge clk) disable iff (rst)
    !busy |-> txd);
  assert_line_moves_on_tick_R2: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(txd));
  assert_start_is_low_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> !txd);
  assert_cts_holds_start_R9: assert property (@(posedge clk) disable iff (rst)
    (!busy && !cts) |=> !busy);
endmodule

// File: rtl/async_tx_fifo.sv
module async_tx_fifo #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 16,
  parameter int TICKS  = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       baud_tick,
  input  logic                       wr_en,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       fmt_len7,
  input  logic                       fmt_stop2,
  input  logic [1:0]                 fmt_parity,
  input  logic                       cts,
  output logic                       txd,
  output logic [$clog2(DEPTH+1)-1:0] fill_level,
  output logic                       empty_irq,
  output logic                       empty_dma_req,
  output logic                       overflow,
  output logic                       tx_done
);
  logic [DATA_W-1:0] head;
  logic              fifo_empty, pop, busy;

  atx_fifo #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_fifo (
    .clk       (clk),
    .rst       (rst),
    .push_req  (wr_en),
    .push_data (wr_data),
    .pop       (pop),
    .head      (head),
    .level     (fill_level),
    .empty     (fifo_empty),
    .overflow  (overflow)
  );

  atx_serializer #(.DATA_W(DATA_W), .TICKS(TICKS)) u_ser (
    .clk       (clk),
    .rst       (rst),
    .tick      (baud_tick),
    .avail     (!fifo_empty),
    .head      (head),
    .cfg_len7  (fmt_len7),
    .cfg_stop2 (fmt_stop2),
    .cfg_par   (fmt_parity),
    .cts       (cts),
    .pop       (pop),
    .txd       (txd),
    .busy      (busy)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      empty_irq     <= 1'b1;
      empty_dma_req <= 1'b1;
      tx_done       <= 1'b1;
    end else begin
      empty_irq     <= fifo_empty;
      empty_dma_req <= fifo_empty;
      tx_done       <= fifo_empty && !busy;
    end
  end

  assert_empty_request_R8: assert property (@(posedge clk) disable iff (rst)
    !rst |=> (empty_irq == ($past(fill_level) == '0)) && (empty_dma_req == empty_irq));
  assert_done_means_idle_R10: assert property (@(posedge clk) disable iff (rst)
    tx_done |-> (txd && empty_irq));
endmodule

// File: tb/async_tx_fifo_tb.sv
`timescale 1ns/1ps
module async_tx_fifo_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       fmt_len7 = 1'b0, fmt_stop2 = 1'b0;
  logic [1:0] fmt_parity = 2'b00;
  logic       cts = 1'b0;
  logic       txd, empty_irq, empty_dma_req, overflow, tx_done;
  logic [4:0] fill_level;
  logic [1:0] tdiv = '0;
  logic       baud_tick;
  int         cyc = 0;
  int         checks = 0, errors = 0;
  logic       nxt_len7, nxt_stop2;
  logic [1:0] nxt_par;

  always #2.5 clk = ~clk;

  always_ff @(posedge clk) begin
    tdiv <= rst ? 2'd0 : tdiv + 2'd1;
    cyc  <= cyc + 1;
  end
  assign baud_tick = (tdiv == 2'd3) && !rst;

  async_tx_fifo u_dut (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .wr_en(wr_en), .wr_data(wr_data),
    .fmt_len7(fmt_len7), .fmt_stop2(fmt_stop2), .fmt_parity(fmt_parity), .cts(cts),
    .txd(txd), .fill_level(fill_level), .empty_irq(empty_irq),
    .empty_dma_req(empty_dma_req), .overflow(overflow), .tx_done(tx_done)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] b);
    @(posedge clk); #1 wr_en = 1'b1; wr_data = b;
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  function automatic int frame_bits(input bit l7, input bit s2, input logic [1:0] p);
    return 1 + (l7 ? 7 : 8) + ((p == 2'b01 || p == 2'b10) ? 1 : 0) + (s2 ? 2 : 1);
  endfunction

  // count low samples on the line over n cycles
  task automatic quiet_lows(input int n, output int lows);
    lows = 0;
    repeat (n) begin
      @(negedge clk);
      if (txd !== 1'b1) lows++;
    end
  endtask

  // decode one character at bit centres: 16 ticks x 4 cycles = 64 cycles per bit
  task automatic rx_frame(input logic [7:0] b, input bit l7, input bit s2,
                          input logic [1:0] p, input bit mid_change, output int t_start);
    int guard = 0;
    int dl = l7 ? 7 : 8;
    logic exp_par;
    @(negedge clk);
    while (txd !== 1'b0 && guard < 20000) begin
      @(negedge clk);
      guard++;
    end
    check("R2 start bit seen", guard < 20000, 1);
    t_start = cyc;
    repeat (32) @(negedge clk);
    check("R2 start bit low", txd, 0);
    check("R10 done low while sending", tx_done, 0);
    if (mid_change) begin
      cts = 1'b0;                       // R9: must not cut this character
      fmt_len7 = nxt_len7; fmt_stop2 = nxt_stop2; fmt_parity = nxt_par;  // R11
    end
    exp_par = 1'b0;
    for (int i = 0; i < dl; i++) begin
      repeat (64) @(negedge clk);
      check(l7 ? "R3 data bit 7-bit mode" : "R2 data bit LSB first", txd, b[i]);
      exp_par ^= b[i];
    end
    if (p == 2'b01 || p == 2'b10) begin
      repeat (64) @(negedge clk);
      check("R4 parity bit", txd, exp_par ^ (p == 2'b10));
    end
    repeat (64) @(negedge clk);
    check("R5 first stop bit", txd, 1);
    if (s2) begin
      repeat (64) @(negedge clk);
      check("R5 second stop bit", txd, 1);
    end
  endtask

  initial begin : watchdog
    wait (cyc == 150000);
    errors++;
    $display("FAIL R2 watchdog actual %0d expected below %0d", cyc, 150000);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    int t1, t2, lows;
    logic [7:0] b1, b2;
    repeat (5) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check("R1 reset txd", txd, 1);
    check("R1 reset fill", fill_level, 0);
    check("R1 reset overflow", overflow, 0);
    check("R1 reset done", tx_done, 1);
    check("R8 reset irq", empty_irq, 1);
    check("R8 reset dma", empty_dma_req, 1);

    // sweep every format, plus the spare no-parity code
    for (int c = 0; c < 13; c++) begin
      bit l7, s2;
      logic [1:0] p;
      l7 = (c < 12) ? c[0] : 1'b0;
      s2 = (c < 12) ? c[1] : 1'b0;
      p  = (c < 12) ? 2'(c / 4) : 2'b11;
      b1 = 8'hA5 ^ 8'(c * 37) | 8'h80;
      b2 = ~b1 | 8'h80;
      cts = 1'b0; fmt_len7 = l7; fmt_stop2 = s2; fmt_parity = p;
      wr(b1); wr(b2);
      @(negedge clk);
      check("R6 fill after two writes", fill_level, 2);
      check("R8 irq low when queued", empty_irq, 0);
      cts = 1'b1;
      rx_frame(b1, l7, s2, p, 1'b0, t1);
      rx_frame(b2, l7, s2, p, 1'b0, t2);
      check("R6 back-to-back spacing", t2 - t1, frame_bits(l7, s2, p) * 64);
      check("R8 irq high while last char sends", empty_irq, 1);
      check("R8 dma high while last char sends", empty_dma_req, 1);
      check("R10 done low during last stop", tx_done, 0);
      repeat (100) @(negedge clk);
      check("R10 done after drain", tx_done, 1);
      check("R6 fill after drain", fill_level, 0);
    end

    // overfill with CTS held off, then drain
    cts = 1'b0; fmt_len7 = 1'b0; fmt_stop2 = 1'b0; fmt_parity = 2'b00;
    for (int i = 0; i < 17; i++) wr(8'(i * 13 + 1));
    @(negedge clk);
    check("R6 fill at capacity", fill_level, 16);
    check("R7 overflow set", overflow, 1);
    cts = 1'b1;
    for (int i = 0; i < 16; i++) rx_frame(8'(i * 13 + 1), 1'b0, 1'b0, 2'b00, 1'b0, t1);
    quiet_lows(700, lows);
    check("R7 dropped byte never sent", lows, 0);
    check("R7 overflow sticky", overflow, 1);
    check("R10 done after overfill drain", tx_done, 1);

    // CTS and format change in mid character
    cts = 1'b0; fmt_parity = 2'b01;
    wr(8'h3C); wr(8'hC3);
    quiet_lows(600, lows);
    check("R9 no start while cts low", lows, 0);
    nxt_len7 = 1'b1; nxt_stop2 = 1'b1; nxt_par = 2'b10;
    cts = 1'b1;
    rx_frame(8'h3C, 1'b0, 1'b0, 2'b01, 1'b1, t1);
    quiet_lows(800, lows);
    check("R9 held after cts drop", lows, 0);
    check("R9 byte still queued", fill_level, 1);
    cts = 1'b1;
    rx_frame(8'hC3, 1'b1, 1'b1, 2'b10, 1'b0, t2);
    repeat (100) @(negedge clk);
    check("R11 done after reformatted char", tx_done, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule